// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral interrupt request lines and the single interrupt interface of a processor. It keeps a pending bit for every source. It compares the enabled pending sources against the priority that is currently in service, and it raises one request line toward the processor whenever a source could preempt the work in progress. A non-maskable line also raises that request.

When the processor samples the acknowledge, the block grants the highest-priority eligible source. One cycle later it presents that source's vector on a strobe that lasts one cycle, and the processor uses the vector as an index into its handler table. Each grant is recorded in an in-service bitmask. That mask acts as a stack of nested grants. A completion pulse from the handler pops the most urgent entry, so the priority level that was active before the interrupt comes back.

Priority is fixed: a lower source index is more urgent, and the non-maskable line sits above every source. A request that is not urgent enough stays pending until the work above it completes. Such a request is never dropped.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `irq_o` and `vec_valid_o` are low and nothing is pending or in service. An acknowledge then returns the spurious vector.
- R2: A source line that is high for one cycle leaves its pending bit set until that source is granted, even after the line falls.
- R3: `irq_o` is high exactly when the non-maskable request is pending, or when some enabled pending source is strictly more urgent than the most urgent in-service entry. Any enabled pending source counts when nothing is in service.
- R4: When several sources are eligible, the one with the lowest index is granted.
- R5: The cycle after `ack_i` is sampled high, `vec_valid_o` is high for that one cycle. For a source with index k, `vec_o` then equals `VEC_BASE + k`. With the defaults (`VEC_BASE`=16, 8 sources), sources 0..7 give vectors 16..23.
- R6: An acknowledge with no eligible request returns the all-ones vector (63 for a 6-bit vector). It changes neither the pending state nor the in-service state.
- R7: A source that is equally or less urgent than the in-service level stays pending and keeps `irq_o` low. It is granted after the completions that uncover it.
- R8: A more urgent source preempts the in-service one. Its grant is added to the in-service mask, so both entries are held.
- R9: A `eoi_i` pulse removes only the most urgent in-service entry, which restores the previous level.
- R10: The non-maskable request has vector 0. It wins over every source, and it is eligible whatever the enables or the in-service level.
- R11: A low `en_i[k]` keeps source k from being eligible but does not stop its pending bit from being captured. The source is granted once it is enabled.
- R12: A grant clears the source's pending bit. If the source's line is still high, the bit is set again on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Level request lines, index 0 most urgent |
| en_i | input | N_SRC | Enable for each maskable source |
| nmi_i | input | 1 | Non-maskable request line |
| ack_i | input | 1 | Acknowledge from the processor |
| eoi_i | input | 1 | Completion pulse from the handler |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector of the granted source |
| vec_valid_o | output | 1 | One-cycle strobe qualifying vec_o |

## Verification
The assertions check the following on every cycle:
- each acknowledge produces exactly one strobe on the next cycle;
- an acknowledge while `irq_o` is low yields the spurious vector;
- a pending non-maskable request raises `irq_o` and takes the next acknowledge with vector 0;
- a completion without an acknowledge drops exactly one in-service entry;
- any non-spurious vector follows a cycle in which `irq_o` was high.

Other properties depend on the history of pending and in-service state, and only the bench's scenarios can show them:
- fixed priority among simultaneous requests;
- nesting and unwinding;
- requests that are held back and later released;
- enables that gate eligibility without discarding the pending bit;
- re-pending from a line that stays high.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;
  typedef enum logic [1:0] {
    GK_NONE = 2'd0,
    GK_NMI  = 2'd1,
    GK_SRC  = 2'd2
  } grant_kind_e;
endpackage

// File: rtl/prio_vec_intc_ffs.sv
// Lowest set index of a request vector.
module prio_vec_intc_ffs #(
  parameter int W  = 9,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc_isr.sv
// In-service mask: push a one-hot grant, pop the most urgent (lowest) bit.
module prio_vec_intc_isr #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] push_i,
  input  logic         pop_i,
  output logic [W-1:0] isr_o
);
  logic [W-1:0] isr_q;
  logic [W-1:0] low_bit;
  logic [W-1:0] isr_d;

  assign low_bit = isr_q & (~isr_q + W'(1));

  always_comb begin
    isr_d = isr_q;
    if (pop_i) isr_d = isr_d & ~low_bit;
    isr_d = isr_d | push_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import prio_vec_intc_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 6,
  parameter int VEC_BASE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             nmi_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  // level 0 = non-maskable, level k+1 = source k
  localparam int NL = N_SRC + 1;
  localparam int IW = $clog2(NL);
  localparam logic [VEC_W-1:0] SPUR_VEC = '1;

  logic [N_SRC-1:0] pend_q;
  logic             nmi_pend_q;
  logic [NL-1:0]    isr_q;
  logic [NL-1:0]    elig;
  logic [NL-1:0]    grant_oh;
  logic             cur_found, win_found;
  logic [IW-1:0]    cur_idx, win_idx;
  logic             grant;
  grant_kind_e      gkind;
  logic [VEC_W-1:0] vec_d;

  prio_vec_intc_ffs #(.W(NL)) u_cur_ffs (
    .req_i  (isr_q),
    .found_o(cur_found),
    .idx_o  (cur_idx)
  );

  assign elig[0] = nmi_pend_q;
  for (genvar k = 0; k < N_SRC; k++) begin : g_elig
    localparam logic [IW-1:0] LVL = IW'(k + 1);
    assign elig[k+1] = pend_q[k] & en_i[k] & (!cur_found || (LVL < cur_idx));
  end

  prio_vec_intc_ffs #(.W(NL)) u_win_ffs (
    .req_i  (elig),
    .found_o(win_found),
    .idx_o  (win_idx)
  );

  assign irq_o    = win_found;
  assign grant    = ack_i & win_found;
  assign grant_oh = grant ? (NL'(1) << win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      nmi_pend_q <= 1'b0;
    end else begin
      pend_q     <= (pend_q | irq_i) & ~grant_oh[NL-1:1];
      nmi_pend_q <= (nmi_pend_q | nmi_i) & ~grant_oh[0];
    end
  end

  prio_vec_intc_isr #(.W(NL)) u_isr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(grant_oh),
    .pop_i (eoi_i),
    .isr_o (isr_q)
  );

  always_comb begin
    if (!win_found)        gkind = GK_NONE;
    else if (win_idx == 0) gkind = GK_NMI;
    else                   gkind = GK_SRC;
  end

  always_comb begin
    unique case (gkind)
      GK_NMI:  vec_d = '0;
      GK_SRC:  vec_d = VEC_W'(VEC_BASE) + VEC_W'(win_idx) - VEC_W'(1);
      default: vec_d = SPUR_VEC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic             nmi_pend,
  input logic [N_SRC:0]   isr
);
  localparam logic [VEC_W-1:0] SPUR = '1;

  p_strobe_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);

  p_no_strobe_without_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o);

  p_spurious_when_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (vec_o == SPUR));

  p_nmi_raises_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend |-> irq_o);

  p_nmi_vector_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && nmi_pend) |=> (vec_o == '0));

  p_eoi_pops_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  p_grant_needs_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && (vec_o != SPUR)) |-> $past(irq_o));
endmodule

bind prio_vec_intc prio_vec_intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .eoi_i      (eoi_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .vec_valid_o(vec_valid_o),
  .nmi_pend   (nmi_pend_q),
  .isr        (isr_q)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int N = 8;
  localparam int VW = 6;
  localparam logic [VW-1:0] SPUR = 6'h3F;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  irq_i = '0;
  logic [N-1:0]  en_i = '1;
  logic          nmi_i = 1'b0;
  logic          ack_i = 1'b0;
  logic          eoi_i = 1'b0;
  logic          irq_o;
  logic [VW-1:0] vec_o;
  logic          vec_valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [VW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  prio_vec_intc #(.N_SRC(N), .VEC_W(VW), .VEC_BASE(16)) u_prio_vec_intc (
    .clk_i, .rst_ni, .irq_i, .en_i, .nmi_i, .ack_i, .eoi_i,
    .irq_o, .vec_o, .vec_valid_o
  );

  // monitor: every strobe must match the next queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && vec_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected strobe vec=%0d expected none", vec_o);
      end else begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec_o !== e) begin
          errors++;
          $display("FAIL %s vec=%0d expected %0d", t, vec_o, e);
        end
      end
    end
  end

  task automatic ack_expect(input logic [VW-1:0] e, input string t);
    @(negedge clk_i);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk_i);
    eoi_i = 1'b1;
    @(negedge clk_i);
    eoi_i = 1'b0;
  endtask

  task automatic pulse_irq(input logic [N-1:0] m, input logic nmi);
    @(negedge clk_i);
    irq_i = m;
    nmi_i = nmi;
    @(negedge clk_i);
    irq_i = '0;
    nmi_i = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk_i);
    #1;
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq_o=%0b expected %0b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_irq(1'b0, "R1 irq after reset");
    checks++;
    if (vec_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 vec_valid=%0b expected 0", vec_valid_o);
    end
    ack_expect(SPUR, "R1 R6 ack after reset");

    // single source, sticky pending
    pulse_irq(8'h08, 1'b0);
    check_irq(1'b1, "R2 R3 pending after pulse");
    ack_expect(6'd19, "R5 vector of source 3");
    check_irq(1'b0, "R3 cleared after grant");

    // less urgent request held back
    pulse_irq(8'h20, 1'b0);
    check_irq(1'b0, "R7 source 5 masked by 3");
    ack_expect(SPUR, "R6 R7 spurious while masked");

    // nesting
    pulse_irq(8'h02, 1'b0);
    check_irq(1'b1, "R8 source 1 preempts");
    ack_expect(6'd17, "R8 nested grant of source 1");
    do_eoi();
    check_irq(1'b0, "R9 source 3 still in service");
    do_eoi();
    check_irq(1'b1, "R7 source 5 released");
    ack_expect(6'd21, "R7 source 5 granted late");
    do_eoi();
    check_irq(1'b0, "R9 all idle");

    // simultaneous requests
    pulse_irq(8'h54, 1'b0);
    ack_expect(6'd18, "R4 source 2 wins");
    check_irq(1'b0, "R4 others less urgent");
    do_eoi();
    ack_expect(6'd20, "R4 source 4 next");
    do_eoi();
    ack_expect(6'd22, "R4 source 6 last");
    do_eoi();

    // enables
    @(negedge clk_i) en_i = 8'hFE;
    pulse_irq(8'h01, 1'b0);
    check_irq(1'b0, "R11 disabled source");
    ack_expect(SPUR, "R11 disabled gives spurious");
    @(negedge clk_i) en_i = 8'hFF;
    check_irq(1'b1, "R11 enabled source pending kept");
    ack_expect(6'd16, "R11 source 0 granted");
    @(negedge clk_i) en_i = 8'h00;
    pulse_irq(8'h00, 1'b1);
    check_irq(1'b1, "R10 nmi unmasked");
    ack_expect(6'd0, "R10 nmi vector");
    do_eoi();
    do_eoi();
    @(negedge clk_i) en_i = 8'hFF;

    // nmi against source 0
    pulse_irq(8'h01, 1'b1);
    ack_expect(6'd0, "R10 nmi beats source 0");
    ack_expect(SPUR, "R7 source 0 held under nmi");
    do_eoi();
    ack_expect(6'd16, "R7 source 0 after nmi");
    do_eoi();

    // line held high through grant
    @(negedge clk_i) irq_i = 8'h80;
    @(negedge clk_i);
    ack_expect(6'd23, "R12 source 7 granted");
    check_irq(1'b0, "R12 in-service masks repend");
    do_eoi();
    check_irq(1'b1, "R12 repended from high line");
    @(negedge clk_i) irq_i = '0;
    ack_expect(6'd23, "R12 second grant");
    do_eoi();
    check_irq(1'b0, "R12 idle at end");

    repeat (3) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 missing strobes actual=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule